// File: doc/BRIEF.md
# Daisy-Chained Serial Register Port

This block is the serial control port of a multi-channel converter. Several identical devices share one chip select, one serial clock and one data line in each direction. A single token line runs from each device to the next. The first byte of every frame is a command. Its top bit selects read (1) or write (0), and its low seven bits select a register. Each device then moves its own share of register data, and hands the token on so that the next device moves its share on the bytes that follow.

Each device holds four registers. The 32-bit sampling-instant register and the 8-bit configuration register are per device, so a chain of N devices moves N times their length in one frame. The 16-bit output-rate register is broadcast: every device in the chain writes it from the same two bytes, and a read returns the first device's copy. The 96-bit conversion-result register is read-only. It is captured from a parallel port when the command is decoded, so every byte of a read comes from the same capture.

The serial pins are sampled by a faster system clock through a synchronizer. Serial-clock edges are detected in the system-clock domain.

Top module: `spi_cascade_slave`

## Requirements
- R1: After reset the data-output enable is 0, the token output is 1, and the sampling-instant, rate and configuration registers are 0.
- R2: The serial clock idles high. Input bits are taken on its falling edges and output bits change after its rising edges, most significant bit first in both directions (a written 32'h80000001 reads back unchanged).
- R3: Command codes (bit 7 = 1 for read): 0x60/0xE0 sampling instant (4 bytes), 0x30/0xB0 configuration (1 byte), 0x50/0xD0 rate (2 bytes). A write followed by a read returns the written value, and the value appears on the register's output port.
- R4: Command 0xF0 reads 12 bytes of the result port. They are captured when the command byte ends, so a later change on the port does not alter that read.
- R5: A device takes part only if its token input is low, with chip select low, at the rising clock edge that ends a byte. It then transfers on the following bytes. With the token input held high, a write leaves the register unchanged and the output stays disabled.
- R6: The token output is low only during the last clock cycle of the last byte of the device's own transfer. It falls after the 7th rising edge of that byte and returns high after the 8th.
- R7: The output enable turns on when chip select falls while the token input is low, or at the byte boundary where the token arrives. It turns off when chip select is high or the device's bytes are done. Two chained devices never drive at once.
- R8: Once its bytes are done, a device ignores further bytes until chip select rises.
- R9: A write takes effect at the rising edge that ends its last byte. If chip select rises earlier, the register keeps its old value.
- R10: A rate write updates every chained device from the same 2 bytes, whatever the chain length, and the token output stays high during it.
- R11: A command with an unknown address (for example 0x10), or a write to the result address (0x70), has no data phase. The output stays disabled and no register changes until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select shared by the chain |
| din | input | 1 | Serial data in |
| cascin_n | input | 1 | Active-low token from the previous device (tie low on the first) |
| dout | output | 1 | Serial data out, valid when dout_oe is 1 |
| dout_oe | output | 1 | Drive enable for the shared output line |
| cascout_n | output | 1 | Active-low token to the next device |
| result_i | input | RES_W | Conversion result, captured at a 0xF0 command |
| samp_dly_o | output | SAMP_W | Sampling-instant register |
| rate_o | output | RATE_W | Output-rate register |
| cfg_o | output | CFG_W | Configuration register |

## Verification
The critical coincidence is the handoff between two chained devices. At one serial rising edge the upstream device finishes its last byte: its enable drops, its token output is released and its write commits. At that same edge the downstream device takes the token, enables its driver and loads its first output bit. The bench builds a two-device chain and runs chained writes and reads of the sampling-instant register across this boundary. It judges the result by the bytes returned from each device, by where the upstream token pulse falls, and by a monitor that counts any system-clock cycle in which both enables are high.

// File: rtl/spi_cascade_pkg.sv
package spi_cascade_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_WAIT,
        PH_XFER,
        PH_DONE,
        PH_BAD
    } phase_e;

    typedef enum logic [1:0] {
        K_SAMP,
        K_RATE,
        K_CFG,
        K_DATA
    } kind_e;

    localparam logic [6:0] ADDR_SAMP = 7'h60;
    localparam logic [6:0] ADDR_RATE = 7'h50;
    localparam logic [6:0] ADDR_CFG  = 7'h30;
    localparam logic [6:0] ADDR_DATA = 7'h70;

endpackage

// File: rtl/spi_cascade_sync.sv
module spi_cascade_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    input  logic cascin_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csn_s,
    output logic csn_fall,
    output logic din_s,
    output logic casc_s
);
    // bit order in each stage: {sclk, cs_n, din, cascin_n}
    localparam logic [3:0] IDLE_PINS = 4'b1101;

    typedef struct packed {
        logic [STAGES-1:0][3:0] pipe;
        logic                   sclk_prev;
        logic                   csn_prev;
    } sync_t;

    sync_t d, q;
    logic [3:0] last;

    assign last = q.pipe[STAGES-1];

    always_comb begin
        d = q;
        d.pipe[0] = {sclk, cs_n, din, cascin_n};
        for (int i = 1; i < STAGES; i++) begin
            d.pipe[i] = q.pipe[i-1];
        end
        d.sclk_prev = last[3];
        d.csn_prev  = last[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= {{STAGES{IDLE_PINS}}, 1'b1, 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = last[3] & ~q.sclk_prev;
    assign sclk_fall = ~last[3] & q.sclk_prev;
    assign csn_s     = last[2];
    assign csn_fall  = ~last[2] & q.csn_prev;
    assign din_s     = last[1];
    assign casc_s    = last[0];

endmodule

// File: rtl/spi_cascade_decode.sv
module spi_cascade_decode
    import spi_cascade_pkg::*;
#(
    parameter int SAMP_BYTES = 4,
    parameter int RATE_BYTES = 2,
    parameter int CFG_BYTES  = 1,
    parameter int DATA_BYTES = 12,
    parameter int CNT_W      = 4
) (
    input  logic [7:0]       cmd,
    output logic             valid,
    output logic             is_read,
    output kind_e            kind,
    output logic [CNT_W-1:0] nbytes
);
    always_comb begin
        is_read = cmd[7];
        valid   = 1'b1;
        kind    = K_CFG;
        nbytes  = '0;
        case (cmd[6:0])
            ADDR_SAMP: begin
                kind   = K_SAMP;
                nbytes = CNT_W'(SAMP_BYTES);
            end
            ADDR_RATE: begin
                kind   = K_RATE;
                nbytes = CNT_W'(RATE_BYTES);
            end
            ADDR_CFG: begin
                kind   = K_CFG;
                nbytes = CNT_W'(CFG_BYTES);
            end
            ADDR_DATA: begin
                kind   = K_DATA;
                nbytes = CNT_W'(DATA_BYTES);
                valid  = cmd[7];
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_cascade_store.sv
module spi_cascade_store
    import spi_cascade_pkg::*;
#(
    parameter int SAMP_W = 32,
    parameter int RATE_W = 16,
    parameter int CFG_W  = 8,
    parameter int RES_W  = 96,
    parameter int WR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  kind_e             wr_kind,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              snap_ld,
    input  logic [RES_W-1:0]  result_i,
    output logic [SAMP_W-1:0] samp_q,
    output logic [RATE_W-1:0] rate_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [RES_W-1:0]  snap_q
);
    typedef struct packed {
        logic [SAMP_W-1:0] samp;
        logic [RATE_W-1:0] rate;
        logic [CFG_W-1:0]  cfg;
        logic [RES_W-1:0]  snap;
    } store_t;

    store_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_kind)
                K_SAMP:  d.samp = wr_data[SAMP_W-1:0];
                K_RATE:  d.rate = wr_data[RATE_W-1:0];
                K_CFG:   d.cfg  = wr_data[CFG_W-1:0];
                default: d.samp = q.samp;
            endcase
        end
        if (snap_ld) begin
            d.snap = result_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign samp_q = q.samp;
    assign rate_q = q.rate;
    assign cfg_q  = q.cfg;
    assign snap_q = q.snap;

    AST_WRITE_NOT_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !snap_ld); // R4

    AST_NO_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_kind != K_DATA); // R11

endmodule

// File: rtl/spi_cascade_slave.sv
module spi_cascade_slave
    import spi_cascade_pkg::*;
#(
    parameter int SAMP_W      = 32,
    parameter int RATE_W      = 16,
    parameter int CFG_W       = 8,
    parameter int RES_W       = 96,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              cascin_n,
    output logic              dout,
    output logic              dout_oe,
    output logic              cascout_n,
    input  logic [RES_W-1:0]  result_i,
    output logic [SAMP_W-1:0] samp_dly_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [CFG_W-1:0]  cfg_o
);
    localparam int SAMP_BYTES = SAMP_W / 8;
    localparam int RATE_BYTES = RATE_W / 8;
    localparam int CFG_BYTES  = CFG_W / 8;
    localparam int DATA_BYTES = RES_W / 8;
    localparam int WR_W  = (SAMP_W > RATE_W) ? ((SAMP_W > CFG_W) ? SAMP_W : CFG_W)
                                             : ((RATE_W > CFG_W) ? RATE_W : CFG_W);
    localparam int TX_W  = (RES_W > WR_W) ? RES_W : WR_W;
    localparam int CNT_W = $clog2(TX_W / 8 + 1);

    typedef struct packed {
        phase_e           phase;
        logic [3:0]       bitcnt;
        logic [CNT_W-1:0] left;
        kind_e            kind;
        logic             rd;
        logic             bcast;
        logic             oe;
        logic             co_n;
        logic [WR_W-1:0]  rx;
        logic [TX_W-1:0]  tx;
    } ctl_t;

    ctl_t d, q;

    logic sclk_rise, sclk_fall, csn_s, csn_fall, din_s, casc_s;
    logic dec_valid, dec_read;
    kind_e dec_kind;
    logic [CNT_W-1:0] dec_nbytes;
    logic [SAMP_W-1:0] samp_q;
    logic [RATE_W-1:0] rate_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [RES_W-1:0]  snap_q;
    logic commit, snap_ld, load_en, byte_end;
    kind_e ld_kind;
    logic ld_read;
    logic [TX_W-1:0] tx_src;

    spi_cascade_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .cascin_n  (cascin_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .csn_s     (csn_s),
        .csn_fall  (csn_fall),
        .din_s     (din_s),
        .casc_s    (casc_s)
    );

    spi_cascade_decode #(
        .SAMP_BYTES (SAMP_BYTES),
        .RATE_BYTES (RATE_BYTES),
        .CFG_BYTES  (CFG_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .CNT_W      (CNT_W)
    ) u_dec (
        .cmd     (q.rx[7:0]),
        .valid   (dec_valid),
        .is_read (dec_read),
        .kind    (dec_kind),
        .nbytes  (dec_nbytes)
    );

    spi_cascade_store #(
        .SAMP_W (SAMP_W),
        .RATE_W (RATE_W),
        .CFG_W  (CFG_W),
        .RES_W  (RES_W),
        .WR_W   (WR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_kind  (q.kind),
        .wr_data  (q.rx),
        .snap_ld  (snap_ld),
        .result_i (result_i),
        .samp_q   (samp_q),
        .rate_q   (rate_q),
        .cfg_q    (cfg_q),
        .snap_q   (snap_q)
    );

    // Source of the first output bits when a device enters its data phase.
    assign ld_kind = (q.phase == PH_CMD) ? dec_kind : q.kind;
    assign ld_read = (q.phase == PH_CMD) ? dec_read : q.rd;

    always_comb begin
        tx_src = '0;
        if (ld_read) begin
            case (ld_kind)
                K_SAMP: tx_src[TX_W-1 -: SAMP_W] = samp_q;
                K_RATE: tx_src[TX_W-1 -: RATE_W] = rate_q;
                K_CFG:  tx_src[TX_W-1 -: CFG_W]  = cfg_q;
                K_DATA: tx_src[TX_W-1 -: RES_W]  = (q.phase == PH_CMD) ? result_i : snap_q;
                default: tx_src = '0;
            endcase
        end
    end

    always_comb begin
        d        = q;
        commit   = 1'b0;
        snap_ld  = 1'b0;
        load_en  = 1'b0;
        byte_end = sclk_rise && (q.bitcnt == 4'd8);
        if (csn_s) begin
            d.phase  = PH_IDLE;
            d.oe     = 1'b0;
            d.co_n   = 1'b1;
            d.bitcnt = '0;
        end else if (csn_fall) begin
            d.phase  = PH_CMD;
            d.bitcnt = '0;
            d.oe     = ~casc_s;
            d.co_n   = 1'b1;
            d.tx     = '0;
        end else if (q.phase == PH_CMD || q.phase == PH_WAIT || q.phase == PH_XFER) begin
            if (sclk_fall) begin
                d.bitcnt = q.bitcnt + 4'd1;
                d.rx     = {q.rx[WR_W-2:0], din_s};
            end else if (sclk_rise) begin
                d.tx = q.tx << 1;
                if (byte_end) begin
                    d.bitcnt = '0;
                end
                case (q.phase)
                    PH_CMD: begin
                        if (byte_end) begin
                            d.kind  = dec_kind;
                            d.rd    = dec_read;
                            d.left  = dec_nbytes;
                            d.bcast = (dec_kind == K_RATE);
                            if (!dec_valid) begin
                                d.phase = PH_BAD;
                                d.oe    = 1'b0;
                            end else begin
                                snap_ld = (dec_kind == K_DATA);
                                if (dec_kind == K_RATE || !casc_s) begin
                                    d.phase = PH_XFER;
                                    d.oe    = ~casc_s;
                                    load_en = 1'b1;
                                end else begin
                                    d.phase = PH_WAIT;
                                    d.oe    = 1'b0;
                                end
                            end
                        end
                    end
                    PH_WAIT: begin
                        if (byte_end && !casc_s) begin
                            d.phase = PH_XFER;
                            d.oe    = 1'b1;
                            load_en = 1'b1;
                        end
                    end
                    default: begin
                        if (!byte_end && q.bitcnt == 4'd7 &&
                            q.left == CNT_W'(1) && !q.bcast) begin
                            d.co_n = 1'b0;
                        end
                        if (byte_end) begin
                            d.left = q.left - CNT_W'(1);
                            if (q.left == CNT_W'(1)) begin
                                d.phase = PH_DONE;
                                d.oe    = 1'b0;
                                d.co_n  = 1'b1;
                                commit  = ~q.rd;
                            end
                        end
                    end
                endcase
            end
        end
        if (load_en) begin
            d.tx = tx_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.co_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dout       = q.oe & q.tx[TX_W-1];
    assign dout_oe    = q.oe;
    assign cascout_n  = q.co_n;
    assign samp_dly_o = samp_q;
    assign rate_o     = rate_q;
    assign cfg_o      = cfg_q;

    AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !dout_oe); // R7

    AST_TOKEN_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !cascout_n |-> (q.phase == PH_XFER && !q.bcast)); // R6

    AST_TOKEN_HIGH_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        q.bcast && q.phase == PH_XFER |-> cascout_n); // R10

    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_BAD |-> !dout_oe); // R11

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_DONE |-> !commit); // R8

    AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (q.phase == PH_DONE || q.phase == PH_IDLE)); // R9

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_XFER && q.kind == K_DATA |-> !snap_ld); // R4

endmodule

// File: tb/test_spi_cascade_slave.sv
module test_spi_cascade_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic csn = 1'b1;
    logic din = 1'b0;
    logic casc_a = 1'b0;
    logic [95:0] result = '0;

    logic d_a, oe_a, co_a, d_b, oe_b, co_b;
    logic [31:0] samp_a, samp_b;
    logic [15:0] rate_a, rate_b;
    logic [7:0]  cfg_a, cfg_b;
    logic dout_bus;

    int n_chk = 0;
    int n_fail = 0;
    int overlap = 0;

    logic [7:0] txb [0:15];
    logic [7:0] rxb [0:15];
    logic [7:0] cob [0:15];
    logic [7:0] ob  [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cascade_slave i_spi_cascade_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(csn), .din(din),
        .cascin_n(casc_a), .dout(d_a), .dout_oe(oe_a), .cascout_n(co_a),
        .result_i(result), .samp_dly_o(samp_a), .rate_o(rate_a), .cfg_o(cfg_a)
    );

    spi_cascade_slave i_spi_cascade_slave_nxt (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(csn), .din(din),
        .cascin_n(co_a), .dout(d_b), .dout_oe(oe_b), .cascout_n(co_b),
        .result_i(~result), .samp_dly_o(samp_b), .rate_o(rate_b), .cfg_o(cfg_b)
    );

    assign dout_bus = oe_a ? d_a : (oe_b ? d_b : 1'b1);

    always @(negedge clk) begin
        if (oe_a && oe_b) overlap++;
    end

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_frame(input int n);
        csn = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                din = txb[b][i];
                wait_clk(HALF);
                sclk = 1'b0;
                wait_clk(HALF);
                rxb[b][i] = dout_bus;
                cob[b][i] = co_a;
                ob[b][i]  = oe_a;
                sclk = 1'b1;
            end
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(HALF);
    endtask

    // {write cmd, read cmd, byte count, value}
    localparam logic [51:0] VEC [0:4] = '{
        {8'h60, 8'hE0, 4'd4, 32'h12345678},
        {8'h30, 8'hB0, 4'd1, 32'h000000A5},
        {8'h50, 8'hD0, 4'd2, 32'h0000BEEF},
        {8'h60, 8'hE0, 4'd4, 32'h80000001},
        {8'h30, 8'hB0, 4'd1, 32'h0000005A}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] got;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        chk("R1 oe", oe_a, 1'b0);
        chk("R1 token", co_a, 1'b1);
        chk("R1 regs", {samp_a, rate_a, cfg_a}, '0);

        // R7 enable follows chip select with the token input low
        csn = 1'b0;
        wait_clk(HALF);
        chk("R7 oe on at select", oe_a, 1'b1);
        chk("R7 next device off", oe_b, 1'b0);
        csn = 1'b1;
        wait_clk(HALF);
        chk("R7 oe off at deselect", oe_a, 1'b0);

        // R3 table: write then read back
        for (int v = 0; v < 5; v++) begin
            logic [7:0]  wc, rc;
            logic [3:0]  nb;
            logic [31:0] val;
            {wc, rc, nb, val} = VEC[v];
            txb[0] = wc;
            for (int k = 0; k < int'(nb); k++) txb[1+k] = 8'(val >> ((int'(nb)-1-k)*8));
            spi_frame(1 + int'(nb));
            txb[0] = rc;
            spi_frame(1 + int'(nb));
            got = '0;
            for (int k = 0; k < int'(nb); k++) got = (got << 8) | 96'(rxb[1+k]);
            chk("R3 readback", got, 96'(val));
            if (wc == 8'h60) chk("R3 port samp", samp_a, val);
            if (wc == 8'h30) chk("R3 port cfg", cfg_a, val[7:0]);
            if (wc == 8'h50) chk("R10 broadcast rate", {rate_a, rate_b}, {val[15:0], val[15:0]});
            if (val == 32'h80000001) chk("R2 msb first", samp_a, 32'h80000001);
        end

        // R4 capture at command, later change ignored
        result = 96'h0123456789ABCDEF_FEDCBA98;
        txb[0] = 8'hF0;
        for (int k = 1; k < 13; k++) txb[k] = 8'h00;
        fork
            spi_frame(13);
            begin wait_clk(400); result = 96'hDEADBEEF_00112233_44556677; end
        join
        got = '0;
        for (int k = 1; k < 13; k++) got = (got << 8) | 96'(rxb[k]);
        chk("R4 snapshot", got, 96'h0123456789ABCDEF_FEDCBA98);
        chk("R6 token last cycle", cob[12], 8'hFE);
        chk("R6 token high earlier", cob[11], 8'hFF);
        spi_frame(13);
        got = '0;
        for (int k = 1; k < 13; k++) got = (got << 8) | 96'(rxb[k]);
        chk("R4 new capture", got, 96'hDEADBEEF_00112233_44556677);

        // R5 chained write and read across the handoff
        txb[0] = 8'h60;
        txb[1] = 8'hA1; txb[2] = 8'hA2; txb[3] = 8'hA3; txb[4] = 8'hA4;
        txb[5] = 8'hB1; txb[6] = 8'hB2; txb[7] = 8'hB3; txb[8] = 8'hB4;
        spi_frame(9);
        chk("R5 chain write first", samp_a, 32'hA1A2A3A4);
        chk("R5 chain write second", samp_b, 32'hB1B2B3B4);
        txb[0] = 8'hE0;
        spi_frame(9);
        chk("R5 chain read first", {rxb[1], rxb[2], rxb[3], rxb[4]}, 32'hA1A2A3A4);
        chk("R5 chain read second", {rxb[5], rxb[6], rxb[7], rxb[8]}, 32'hB1B2B3B4);
        chk("R6 token at handoff", cob[4], 8'hFE);
        chk("R6 token after own bytes", cob[8], 8'hFF);
        chk("R7 first device off after", ob[5], 8'h00);

        // R5 token input high: no participation
        casc_a = 1'b1;
        txb[0] = 8'h30; txb[1] = 8'hFF;
        spi_frame(2);
        chk("R5 no token cfg kept", cfg_a, 8'h5A);
        chk("R5 no token oe", {ob[0], ob[1]}, 16'h0000);
        casc_a = 1'b0;

        // R8 bytes after own transfer ignored
        txb[0] = 8'h30; txb[1] = 8'h33; txb[2] = 8'h44; txb[3] = 8'h55;
        spi_frame(4);
        chk("R8 first device", cfg_a, 8'h33);
        chk("R8 second device", cfg_b, 8'h44);
        chk("R7 oe off when done", ob[2], 8'h00);

        // R9 early deselect discards write
        txb[0] = 8'h60; txb[1] = 8'h11; txb[2] = 8'h22;
        spi_frame(3);
        chk("R9 aborted write", samp_a, 32'hA1A2A3A4);

        // R10 broadcast rate across chain, token stays high
        txb[0] = 8'h50; txb[1] = 8'h3C; txb[2] = 8'h96;
        spi_frame(3);
        chk("R10 both rates", {rate_a, rate_b}, {16'h3C96, 16'h3C96});
        chk("R10 token high", {cob[1], cob[2]}, 16'hFFFF);

        // R11 unknown address and write to the result address
        txb[0] = 8'h10; txb[1] = 8'hAB;
        spi_frame(2);
        chk("R11 unknown oe", ob[1], 8'h00);
        chk("R11 unknown regs", {cfg_a, rate_a}, {8'h33, 16'h3C96});
        txb[0] = 8'h70; txb[1] = 8'h01; txb[2] = 8'h02; txb[3] = 8'h03; txb[4] = 8'h04;
        spi_frame(5);
        chk("R11 result write oe", ob[1], 8'h00);
        chk("R11 result write regs", samp_a, 32'hA1A2A3A4);

        chk("R7 no double drive", 96'(overlap), 96'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule